// File: doc/BRIEF.md
# Timer Event Flag Bank

This block keeps the pending-event flags of an eight-channel capture/compare timer: one sticky flag per channel plus one flag for counter wrap-around. Event pulses from the channel logic and from the counter set the flags. Software reads them and clears them through a small synchronous register port that has an address, a read strobe, a write strobe and byte-wide data.

Software clears a flag by writing a one to its bit. Such a write only counts while the timer or the pulse accumulator is switched on. There is also an optional fast-clear mode. In that mode a flag is dropped as a side effect of the access that normally follows the event: reading a capture channel's data register, writing a compare channel's data register, or touching the counter register. Each flag ANDed with its interrupt enable feeds a single active-high interrupt request.

Top module: `tmr_event_flags`

## Requirements
- R1: After a synchronous active-low reset, every channel flag and the overflow flag are 0, and `irq` is 0.
- R2: An event pulse on `chan_evt[n]` sets channel flag n, visible on `chan_flags[n]` after the next rising clock edge. A pulse on `ovf_evt` sets `ovf_flag` in the same way.
- R3: A write to offset 0x0E clears each channel flag n whose data bit n is 1. A write to offset 0x0F with data bit 7 at 1 clears the overflow flag. Data bits at 0 leave flags unchanged. Both rules apply only while `tmr_en` or `acc_en` is high.
- R4: While both `tmr_en` and `acc_en` are low, writes of ones to offsets 0x0E and 0x0F change no flag.
- R5: With `bus_rd` high, `bus_rdata` returns the channel flags at offset 0x0E (bit n = channel n) and `{ovf_flag, 7'b0}` at offset 0x0F. It is 0 at any other offset and whenever `bus_rd` is low. Reading these two offsets never changes a flag.
- R6: With `fast_clr` high, a read of offset 0x10+2n or 0x11+2n clears channel flag n when `chan_is_oc[n]` is 0 (input capture). A write to those offsets does not clear it in that mode.
- R7: With `fast_clr` high, a write to offset 0x10+2n or 0x11+2n clears channel flag n when `chan_is_oc[n]` is 1 (output compare). A read of those offsets does not clear it in that mode.
- R8: With `fast_clr` high, a read or a write of offset 0x04 or 0x05 (the counter) clears the overflow flag.
- R9: With `fast_clr` low, accesses to the channel and counter offsets clear no flag.
- R10: When a set event and any clear hit the same flag in the same cycle, the flag ends up set.
- R11: `irq` is high exactly when some `chan_flags[n] & chan_ie[n]` is 1 or `ovf_flag & ovf_ie` is 1.
- R12: Bits 6:0 at offset 0x0F always read 0, and writing them has no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 6 | Register offset of the access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address and strobe |
| chan_evt | input | 8 | Capture/compare event pulses, one per channel |
| ovf_evt | input | 1 | Counter wrap-around pulse |
| tmr_en | input | 1 | Timer enabled |
| acc_en | input | 1 | Pulse accumulator enabled |
| fast_clr | input | 1 | Fast-clear mode on |
| chan_is_oc | input | 8 | Per channel: 1 = output compare, 0 = input capture |
| chan_ie | input | 8 | Per-channel interrupt enables |
| ovf_ie | input | 1 | Overflow interrupt enable |
| chan_flags | output | 8 | Channel flags |
| ovf_flag | output | 1 | Overflow flag |
| irq | output | 1 | Combined interrupt request |

## Verification
Some rules are checked by the assertions on every cycle. An event always leaves its flag set on the next cycle. Ignored writes and disabled fast-clear never lower a flag. Readback at the two flag offsets always matches the flag outputs, and the interrupt request agrees with the enabled flags. Other behaviour only shows up in the bench's scenarios: which access clears which channel, given each channel's capture-or-compare setting. Those scenarios also cover the counter-access clearing of the overflow flag and the exact sequences where clears and events land together. The bench follows every cycle with a reference model.

// File: rtl/tef_pkg.sv
// Package: shared sizes and default register offsets for the timer event
// flag bank. Assumes byte-wide data and a 6-bit register offset space.
package tef_pkg;
    localparam int TEF_NUM_CH   = 8;
    localparam int TEF_ADDR_W   = 6;
    localparam int TEF_DATA_W   = 8;
    localparam int TEF_CNT_OFS  = 'h04;
    localparam int TEF_FLAG_OFS = 'h0E;
    localparam int TEF_OVF_OFS  = 'h0F;
    localparam int TEF_CH_BASE  = 'h10;

    // Clear strobes for one flag, kept apart so the sources stay visible.
    typedef struct packed {
        logic w1c;
        logic fast;
    } tef_clr_t;
endpackage

// File: rtl/tef_access_decode.sv
// Module: turns one bus access into per-flag clear requests.
// Assumes at most one access per cycle and NUM_CH <= DATA_W. Write-one
// clears need tmr_en or acc_en. Fast clears depend only on fast_clr and
// on the channel mode.
module tef_access_decode
    import tef_pkg::*;
#(
    parameter int NUM_CH   = TEF_NUM_CH,
    parameter int ADDR_W   = TEF_ADDR_W,
    parameter int DATA_W   = TEF_DATA_W,
    parameter int CNT_OFS  = TEF_CNT_OFS,
    parameter int FLAG_OFS = TEF_FLAG_OFS,
    parameter int OVF_OFS  = TEF_OVF_OFS,
    parameter int CH_BASE  = TEF_CH_BASE
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              tmr_en,
    input  logic              acc_en,
    input  logic              fast_clr,
    input  logic [NUM_CH-1:0] chan_is_oc,
    output tef_clr_t          ch_clr [NUM_CH],
    output tef_clr_t          ovf_clr,
    output logic              sel_flag,
    output logic              sel_ovf
);
    localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(FLAG_OFS);
    localparam logic [ADDR_W-1:0] A_OVF  = ADDR_W'(OVF_OFS);
    localparam logic [ADDR_W-1:0] A_CNT0 = ADDR_W'(CNT_OFS);
    localparam logic [ADDR_W-1:0] A_CNT1 = ADDR_W'(CNT_OFS + 1);
    localparam int                OVF_BIT = DATA_W - 1;

    logic clr_allowed;
    logic cnt_hit;

    // Purpose: address matches for the flag registers and the counter.
    always_comb begin
        clr_allowed = tmr_en | acc_en;
        sel_flag    = (bus_addr == A_FLAG);
        sel_ovf     = (bus_addr == A_OVF);
        cnt_hit     = (bus_addr == A_CNT0) || (bus_addr == A_CNT1);
    end

    // Purpose: clear requests for the overflow flag.
    always_comb begin
        ovf_clr.w1c  = bus_wr && sel_ovf && clr_allowed && bus_wdata[OVF_BIT];
        ovf_clr.fast = fast_clr && (bus_rd || bus_wr) && cnt_hit;
    end

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(CH_BASE + 2 * n);
        localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(CH_BASE + 2 * n + 1);
        logic ch_hit;
        logic trig;

        // Purpose: clear requests for channel n; the mode picks read or write.
        always_comb begin
            ch_hit         = (bus_addr == A_LO) || (bus_addr == A_HI);
            trig           = chan_is_oc[n] ? bus_wr : bus_rd;
            ch_clr[n].w1c  = bus_wr && sel_flag && clr_allowed && bus_wdata[n];
            ch_clr[n].fast = fast_clr && ch_hit && trig;
        end
    end
endmodule

// File: rtl/tef_flag_cell.sv
// Module: one sticky event flag. It is set by a pulse and cleared by either
// clear source. A set and a clear in the same cycle leave the flag set.
// Assumes a synchronous active-low reset.
module tef_flag_cell
    import tef_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     set_i,
    input  tef_clr_t clr_i,
    output logic     flag_q
);
    // Purpose: set has priority over clear, and the flag holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                       flag_q <= 1'b0;
        else if (set_i)                   flag_q <= 1'b1;
        else if (clr_i.w1c || clr_i.fast) flag_q <= 1'b0;
    end

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_q);
endmodule

// File: rtl/tef_irq_merge.sv
// Module: gates each flag with its enable and ORs the results into one
// active-high request. Purely combinational.
module tef_irq_merge #(
    parameter int NUM_CH = 8
) (
    input  logic [NUM_CH-1:0] chan_flags,
    input  logic [NUM_CH-1:0] chan_ie,
    input  logic              ovf_flag,
    input  logic              ovf_ie,
    output logic              irq
);
    // Purpose: combine the enabled flags into one request.
    always_comb irq = (|(chan_flags & chan_ie)) | (ovf_flag & ovf_ie);
endmodule

// File: rtl/tmr_event_flags.sv
// Module: top of the timer event flag bank. Holds NUM_CH channel flags and
// one overflow flag, decodes bus accesses into clears, returns readback and
// raises a combined interrupt. Assumes one access per cycle.
module tmr_event_flags
    import tef_pkg::*;
#(
    parameter int NUM_CH   = TEF_NUM_CH,
    parameter int ADDR_W   = TEF_ADDR_W,
    parameter int DATA_W   = TEF_DATA_W,
    parameter int CNT_OFS  = TEF_CNT_OFS,
    parameter int FLAG_OFS = TEF_FLAG_OFS,
    parameter int OVF_OFS  = TEF_OVF_OFS,
    parameter int CH_BASE  = TEF_CH_BASE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] chan_evt,
    input  logic              ovf_evt,
    input  logic              tmr_en,
    input  logic              acc_en,
    input  logic              fast_clr,
    input  logic [NUM_CH-1:0] chan_is_oc,
    input  logic [NUM_CH-1:0] chan_ie,
    input  logic              ovf_ie,
    output logic [NUM_CH-1:0] chan_flags,
    output logic              ovf_flag,
    output logic              irq
);
    localparam int PAD_W = DATA_W - NUM_CH;

    tef_clr_t ch_clr [NUM_CH];
    tef_clr_t ovf_clr;
    logic     sel_flag;
    logic     sel_ovf;

    tef_access_decode #(
        .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .CNT_OFS(CNT_OFS), .FLAG_OFS(FLAG_OFS), .OVF_OFS(OVF_OFS),
        .CH_BASE(CH_BASE)
    ) i_decode (
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .tmr_en    (tmr_en),
        .acc_en    (acc_en),
        .fast_clr  (fast_clr),
        .chan_is_oc(chan_is_oc),
        .ch_clr    (ch_clr),
        .ovf_clr   (ovf_clr),
        .sel_flag  (sel_flag),
        .sel_ovf   (sel_ovf)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_flag
        tef_flag_cell i_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (chan_evt[n]),
            .clr_i (ch_clr[n]),
            .flag_q(chan_flags[n])
        );
    end

    tef_flag_cell i_ovf_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (ovf_evt),
        .clr_i (ovf_clr),
        .flag_q(ovf_flag)
    );

    tef_irq_merge #(.NUM_CH(NUM_CH)) i_irq (
        .chan_flags(chan_flags),
        .chan_ie   (chan_ie),
        .ovf_flag  (ovf_flag),
        .ovf_ie    (ovf_ie),
        .irq       (irq)
    );

    // Purpose: readback mux; returns 0 when no flag register is read.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd && sel_flag) begin
            if (PAD_W > 0) bus_rdata = DATA_W'(chan_flags);
            else           bus_rdata = chan_flags[DATA_W-1:0];
        end else if (bus_rd && sel_ovf) begin
            bus_rdata[DATA_W-1] = ovf_flag;
        end
    end

    // R5
    rd_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(FLAG_OFS)) |-> bus_rdata == DATA_W'(chan_flags));
    // R12
    rd_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(OVF_OFS)) |->
            (bus_rdata[DATA_W-2:0] == '0 && bus_rdata[DATA_W-1] == ovf_flag));
    // R4
    no_w1c_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !tmr_en && !acc_en && !fast_clr) |=>
            ((chan_flags & $past(chan_flags)) == $past(chan_flags)
             && (ovf_flag || !$past(ovf_flag))));
    // R9
    no_fast_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fast_clr && !(bus_wr && (bus_addr == ADDR_W'(FLAG_OFS)
                                   || bus_addr == ADDR_W'(OVF_OFS)))) |=>
            ((chan_flags & $past(chan_flags)) == $past(chan_flags)
             && (ovf_flag || !$past(ovf_flag))));
    // R11
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((|(chan_flags & chan_ie)) || (ovf_flag && ovf_ie)));
    // R11
    irq_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(chan_flags & chan_ie)) || (ovf_flag && ovf_ie)) |-> irq);
endmodule

// File: tb/test_tmr_event_flags.sv
module test_tmr_event_flags;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic [7:0] chan_evt = '0;
    logic       ovf_evt = 1'b0;
    logic       tmr_en = 1'b0, acc_en = 1'b0, fast_clr = 1'b0;
    logic [7:0] chan_is_oc = '0, chan_ie = '0;
    logic       ovf_ie = 1'b0;
    logic [7:0] chan_flags;
    logic       ovf_flag, irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] m_ch = '0;
    logic       m_ovf = 1'b0;

    always #5 clk = ~clk;

    tmr_event_flags i_tmr_event_flags (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .chan_evt(chan_evt), .ovf_evt(ovf_evt), .tmr_en(tmr_en),
        .acc_en(acc_en), .fast_clr(fast_clr), .chan_is_oc(chan_is_oc),
        .chan_ie(chan_ie), .ovf_ie(ovf_ie), .chan_flags(chan_flags),
        .ovf_flag(ovf_flag), .irq(irq)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference: next channel flags from the requirements
    function automatic logic [7:0] next_ch(logic [5:0] a, logic rd, logic wr,
                                           logic [7:0] wd, logic [7:0] ev);
        logic [7:0] r = m_ch;
        for (int n = 0; n < 8; n++) begin
            logic clr;
            clr = (wr && a == 6'h0E && (tmr_en || acc_en) && wd[n])
               || (fast_clr && (a == 6'(16 + 2*n) || a == 6'(17 + 2*n))
                   && (chan_is_oc[n] ? wr : rd));
            if (ev[n]) r[n] = 1'b1;
            else if (clr) r[n] = 1'b0;
        end
        return r;
    endfunction

    function automatic logic next_ovf(logic [5:0] a, logic rd, logic wr,
                                      logic [7:0] wd, logic ev);
        logic clr;
        clr = (wr && a == 6'h0F && (tmr_en || acc_en) && wd[7])
           || (fast_clr && (rd || wr) && (a == 6'h04 || a == 6'h05));
        if (ev) return 1'b1;
        return clr ? 1'b0 : m_ovf;
    endfunction

    function automatic logic [7:0] exp_rd(logic [5:0] a, logic rd);
        if (!rd) return 8'h00;
        if (a == 6'h0E) return m_ch;
        if (a == 6'h0F) return {m_ovf, 7'b0};
        return 8'h00;
    endfunction

    // One bus cycle: drive at the falling edge, check readback, then flags.
    task automatic step(logic [5:0] a, logic rd, logic wr, logic [7:0] wd,
                        logic [7:0] ev, logic ov, string tag);
        logic [7:0] nc;
        logic       no;
        bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = wd;
        chan_evt = ev; ovf_evt = ov;
        #1;
        check("R5 readback", 32'(bus_rdata), 32'(exp_rd(a, rd)));
        nc = next_ch(a, rd, wr, wd, ev);
        no = next_ovf(a, rd, wr, wd, ov);
        @(posedge clk);
        @(negedge clk);
        m_ch = nc; m_ovf = no;
        bus_rd = 1'b0; bus_wr = 1'b0; chan_evt = '0; ovf_evt = 1'b0;
        check({tag, " chan_flags"}, 32'(chan_flags), 32'(m_ch));
        check({tag, " ovf_flag"}, 32'(ovf_flag), 32'(m_ovf));
        check("R11 irq", 32'(irq),
              32'((|(m_ch & chan_ie)) || (m_ovf && ovf_ie)));
    endtask

    initial begin : watchdog
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset chan_flags", 32'(chan_flags), 0);
        check("R1 reset ovf_flag", 32'(ovf_flag), 0);
        check("R1 reset irq", 32'(irq), 0);

        // R2 set by events
        step(6'h00, 0, 0, 8'h00, 8'hA5, 1, "R2");
        // R4 write-one ignored with both enables low
        step(6'h0E, 0, 1, 8'hFF, 8'h00, 0, "R4");
        step(6'h0F, 0, 1, 8'h80, 8'h00, 0, "R4");
        // R12 low bits of overflow register: no effect, read as 0
        tmr_en = 1;
        step(6'h0F, 0, 1, 8'h7F, 8'h00, 0, "R12");
        step(6'h0F, 1, 0, 8'h00, 8'h00, 0, "R12");
        // R3 write-one clear, zeros hold
        step(6'h0E, 0, 1, 8'h05, 8'h00, 0, "R3");
        tmr_en = 0; acc_en = 1;
        step(6'h0F, 0, 1, 8'h80, 8'h00, 0, "R3");
        step(6'h0E, 1, 0, 8'h00, 8'h00, 0, "R5");
        // R9 fast clear off: channel and counter accesses keep flags
        step(6'h00, 0, 0, 8'h00, 8'hFF, 1, "R2");
        step(6'h14, 1, 0, 8'h00, 8'h00, 0, "R9");
        step(6'h05, 1, 1, 8'h00, 8'h00, 0, "R9");
        // R6 capture channel 2: write keeps, read clears
        fast_clr = 1; chan_is_oc = 8'hF0;
        step(6'h15, 0, 1, 8'h12, 8'h00, 0, "R6");
        step(6'h15, 1, 0, 8'h00, 8'h00, 0, "R6");
        // R7 compare channel 7: read keeps, write clears
        step(6'h1E, 1, 0, 8'h00, 8'h00, 0, "R7");
        step(6'h1E, 0, 1, 8'h34, 8'h00, 0, "R7");
        // R8 counter access clears overflow
        step(6'h04, 1, 0, 8'h00, 8'h00, 0, "R8");
        step(6'h00, 0, 0, 8'h00, 8'h00, 1, "R2");
        step(6'h05, 0, 1, 8'h00, 8'h00, 0, "R8");
        // R10 set wins over every clear source
        step(6'h0E, 0, 1, 8'h01, 8'h01, 0, "R10");
        step(6'h10, 1, 0, 8'h00, 8'h01, 0, "R10");
        step(6'h04, 1, 0, 8'h00, 8'h00, 1, "R10");
        // R11 interrupt with enables
        chan_ie = 8'h02; ovf_ie = 1;
        step(6'h00, 0, 0, 8'h00, 8'h00, 0, "R11");
        step(6'h0F, 0, 1, 8'h80, 8'h00, 0, "R11");
        step(6'h0E, 0, 1, 8'h02, 8'h00, 0, "R11");

        // Constrained random mix
        for (int i = 0; i < 3000; i++) begin
            logic [5:0] a;
            logic rd, wr;
            int sel;
            if (i % 64 == 0) begin
                tmr_en = 1'($urandom); acc_en = 1'($urandom);
                fast_clr = 1'($urandom); chan_is_oc = 8'($urandom);
                chan_ie = 8'($urandom); ovf_ie = 1'($urandom);
            end
            sel = int'($urandom % 6);
            case (sel)
                0: a = 6'h0E;
                1: a = 6'h0F;
                2: a = 6'h04 + 6'($urandom % 2);
                3, 4: a = 6'h10 + 6'($urandom % 16);
                default: a = 6'($urandom);
            endcase
            rd = 1'($urandom); wr = !rd && 1'($urandom);
            step(a, rd, wr, 8'($urandom),
                 8'($urandom) & 8'($urandom) & 8'($urandom),
                 ($urandom % 6) == 0, "R2 R3 R6 R7 R8 R10 random");
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule